// File: doc/BRIEF.md
# Prescaled Compare Timer with Modulus Reset

This block is a 16-bit up-counter that advances on ticks produced by a power-of-two divider from the bus clock. Eight compare channels watch the count, and each has its own sticky flag and interrupt enable. A separate overflow flag records a natural wrap of the counter. An optional modulus mode makes a channel-7 match return the counter to zero. Software reaches all state through a small synchronous register bus with single-cycle writes and combinational reads.

Register map (word addresses on `bus_addr`): 0 is control, 1 is run, 2 is channel interrupt enables, 3 is channel flags, 4 is the overflow flag, 5 is the counter (read-only), and 8 to 15 are the compare values of channels 0 to 7. Unmapped addresses read as zero. The block drives two outputs: a combined channel interrupt and an overflow interrupt.

Top module: `ptimer_top`

## Requirements
- R1: After reset every register, the counter and both interrupt outputs are 0.
- R2: While the run register (address 1, bit 0) is 0, the counter does not change.
- R3: With divider select value p in control bits 2:0, a running counter advances exactly once every 2^p clocks.
- R4: The control register at address 0 holds the overflow interrupt enable in bit 7, the modulus enable in bit 3 and the divider select in bits 2:0. Bits 6:4 and all higher bits read as 0.
- R5: On a tick where the counter equals the compare value of channel n, bit n of the flag register (address 3) becomes 1 after that edge.
- R6: Writing 1 to a flag bit (address 3 bits 7:0, address 4 bit 0) clears it. Writing 0 leaves it unchanged.
- R7: `chan_irq` is high exactly when some flag bit is set and the matching enable bit (address 2) is also set.
- R8: With modulus mode off, a tick at count 0xFFFF moves the counter to 0x0000 and sets the overflow flag. `ovf_irq` is high while that flag and control bit 7 are both 1.
- R9: With modulus mode on, a tick where the count equals the channel-7 compare value loads 0x0000.
- R10: With modulus mode on and a channel-7 compare value of 0x0000, the counter stays at 0x0000.
- R11: With modulus mode on and a channel-7 compare value of 0xFFFF, the step from 0xFFFF to 0x0000 leaves the overflow flag clear.
- R12: When a match and a write-1 clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| chan_irq | output | 1 | Combined, enabled channel interrupt |
| ovf_irq | output | 1 | Enabled overflow interrupt |

## Verification
The counter is run under several patterns. The first is a channel-7 compare of zero in modulus mode, which tells a counter pinned at zero apart from one that slips a step. The second is a small modulus, which separates a reload at the match from a reload one count late. Two full-range runs follow: a free-running wrap and a modulus at 0xFFFF. Their overflow flags must differ, and this is the only thing that tells the natural wrap apart from the compare reload. A divide-by-four run, sampled over a fixed window, exposes a wrong divider phase or ratio. A flag clear issued on the exact match cycle shows whether set or clear takes priority.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 4'd0;
  localparam addr_t A_RUN  = 4'd1;
  localparam addr_t A_IE   = 4'd2;
  localparam addr_t A_FLG  = 4'd3;
  localparam addr_t A_OVF  = 4'd4;
  localparam addr_t A_CNT  = 4'd5;
  localparam addr_t A_CMP0 = 4'd8;

  localparam int CTRL_OVF_IE_BIT = 7;
  localparam int CTRL_MOD_BIT    = 3;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  // low 'sel' bits set: divider phase that ends a period
  function automatic logic [PRE_W-1:0] ratio_mask(input logic [PSEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    for (int k = 0; k < PRE_W; k++) m[k] = (k < int'(sel));
    return m;
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = ratio_mask(psel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_q <= '0;
    else                pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mod_en,
  input  logic [CNT_W-1:0] top_cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             mod_hit,
  output logic             wrap_ovf
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic reload);
    return reload ? '0 : c + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign cnt      = cnt_q;
  assign mod_hit  = tick && mod_en && (cnt_q == top_cmp);
  // a compare reload at all-ones is not a wrap
  assign wrap_ovf = tick && (cnt_q == '1) && !mod_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= next_count(cnt_q, mod_hit);
  end
endmodule

// File: rtl/ptimer_channels.sv
module ptimer_channels #(
  parameter int CNT_W = 16,
  parameter int NCH   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NCH*CNT_W-1:0] cmp_flat,
  input  logic [NCH-1:0]       clr_mask,
  output logic [NCH-1:0]       hit,
  output logic [NCH-1:0]       flags
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = tick && (cnt == cmp_flat[i*CNT_W +: CNT_W]);

    always_ff @(posedge clk) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (hit[i])      flags[i] <= 1'b1;
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 8,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              chan_irq,
  output logic              ovf_irq
);
  logic                          ovf_ie_q, mod_en_q, run_q, ovf_flag_q;
  logic [PSEL_W-1:0]             psel_q;
  logic [NCH-1:0]                chan_ie_q;
  logic [NCH-1:0][CNT_W-1:0]     cmp_q;
  logic                          tick, mod_hit, wrap_ovf;
  logic [CNT_W-1:0]              cnt_q;
  logic [NCH-1:0]                chan_hit, chan_flag, clr_mask;
  logic                          wr_ctrl, wr_run, wr_ie, wr_flg, wr_ovf;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_run   = bus_wr && (bus_addr == A_RUN);
  assign wr_ie    = bus_wr && (bus_addr == A_IE);
  assign wr_flg   = bus_wr && (bus_addr == A_FLG);
  assign wr_ovf   = bus_wr && (bus_addr == A_OVF);
  assign clr_mask = wr_flg ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_ie_q  <= 1'b0;
      mod_en_q  <= 1'b0;
      psel_q    <= '0;
      run_q     <= 1'b0;
      chan_ie_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ovf_ie_q <= bus_wdata[CTRL_OVF_IE_BIT];
        mod_en_q <= bus_wdata[CTRL_MOD_BIT];
        psel_q   <= bus_wdata[PSEL_W-1:0];
      end
      if (wr_run) run_q     <= bus_wdata[0];
      if (wr_ie)  chan_ie_q <= bus_wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_q[i] <= '0;
      else if (bus_wr && (bus_addr == addr_t'(int'(A_CMP0) + i))) cmp_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ovf_flag_q <= 1'b0;
    else if (wrap_ovf)               ovf_flag_q <= 1'b1;
    else if (wr_ovf && bus_wdata[0]) ovf_flag_q <= 1'b0;
  end

  ptimer_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .psel(psel_q), .tick(tick)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_en(mod_en_q),
    .top_cmp(cmp_q[NCH-1]), .cnt(cnt_q), .mod_hit(mod_hit), .wrap_ovf(wrap_ovf)
  );

  ptimer_channels #(.CNT_W(CNT_W), .NCH(NCH)) u_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q), .cmp_flat(cmp_q),
    .clr_mask(clr_mask), .hit(chan_hit), .flags(chan_flag)
  );

  assign chan_irq = |(chan_flag & chan_ie_q);
  assign ovf_irq  = ovf_flag_q && ovf_ie_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTRL_OVF_IE_BIT] = ovf_ie_q;
        bus_rdata[CTRL_MOD_BIT]    = mod_en_q;
        bus_rdata[PSEL_W-1:0]      = psel_q;
      end
      A_RUN:   bus_rdata[0]       = run_q;
      A_IE:    bus_rdata[NCH-1:0] = chan_ie_q;
      A_FLG:   bus_rdata[NCH-1:0] = chan_flag;
      A_OVF:   bus_rdata[0]       = ovf_flag_q;
      A_CNT:   bus_rdata          = cnt_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == addr_t'(int'(A_CMP0) + i)) bus_rdata = cmp_q[i];
      end
    endcase
  end
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
  parameter int CNT_W = 16,
  parameter int NCH   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run_en,
  input logic             mod_en,
  input logic             ovf_ie,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_cmp,
  input logic [CNT_W-1:0] cmp0,
  input logic [NCH-1:0]   chan_flags,
  input logic [NCH-1:0]   chan_ie,
  input logic             ovf_flag,
  input logic             chan_irq,
  input logic             ovf_irq
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt));

  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp0) |=> chan_flags[0]);

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_ie == '0) |-> !chan_irq);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mod_en && cnt == '1) |=> (ovf_flag && cnt == '0));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !ovf_irq);

  a_r9_mod_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mod_en && cnt == top_cmp) |=> (cnt == '0));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mod_en && top_cmp == '1 && cnt == '1 && !ovf_flag) |=> !ovf_flag);
endmodule

bind ptimer_top ptimer_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_q), .mod_en(mod_en_q),
  .ovf_ie(ovf_ie_q), .cnt(cnt_q), .top_cmp(cmp_q[NCH-1]), .cmp0(cmp_q[0]),
  .chan_flags(chan_flag), .chan_ie(chan_ie_q), .ovf_flag(ovf_flag_q),
  .chan_irq(chan_irq), .ovf_irq(ovf_irq)
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 4'd5;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        chan_irq, ovf_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int       m_cnt = 0, m_pc = 0, m_ps = 0;
  bit       m_run = 0, m_mod = 0, m_ovfie = 0, m_ovf = 0;
  bit [7:0] m_ie = 0, m_flags = 0;
  int       m_cmp [8];

  always #4 clk = ~clk;

  ptimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_irq(chan_irq), .ovf_irq(ovf_irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int  period = 1 << m_ps;
    bit  tk = m_run && ((m_pc % period) == period - 1);
    bit  reload = tk && m_mod && (m_cnt == m_cmp[7]);
    bit  wrap = tk && (m_cnt == 65535) && !reload;
    bit [7:0] hits = 0;
    for (int i = 0; i < 8; i++) if (tk && m_cnt == m_cmp[i]) hits[i] = 1;
    if (bus_wr && bus_addr == 3) m_flags &= ~bus_wdata[7:0];
    m_flags |= hits;
    if (bus_wr && bus_addr == 4 && bus_wdata[0]) m_ovf = 0;
    if (wrap) m_ovf = 1;
    m_pc = m_run ? (m_pc + 1) % 128 : 0;
    if (tk) m_cnt = reload ? 0 : (m_cnt + 1) % 65536;
    if (bus_wr) begin
      case (bus_addr)
        0: begin m_ovfie = bus_wdata[7]; m_mod = bus_wdata[3]; m_ps = bus_wdata[2:0]; end
        1: m_run = bus_wdata[0];
        2: m_ie = bus_wdata[7:0];
        default: if (bus_addr >= 8) m_cmp[bus_addr - 8] = bus_wdata;
      endcase
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R7 chan_irq", chan_irq, (m_flags & m_ie) != 0);
    chk("R8 ovf_irq", ovf_irq, m_ovf && m_ovfie);
    if (!bus_wr && bus_addr == 5) chk("R3 counter", bus_rdata, m_cnt);
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
    cycle();
    bus_wr = 0; bus_addr = 4'd5; bus_wdata = 0;
  endtask

  task automatic rd(string tag, int a, int mask, int exp);
    bus_addr = 4'(a);
    #1;
    chk(tag, bus_rdata & mask, exp);
    bus_addr = 4'd5;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wait_cnt(int v, int lim);
    for (int i = 0; i < lim && m_cnt != v; i++) cycle();
  endtask

  initial begin
    int c0;
    for (int i = 0; i < 8; i++) m_cmp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) rd("R1 reset reg", a, 16'hFFFF, 0);
    chk("R1 chan_irq", chan_irq, 0);
    chk("R1 ovf_irq", ovf_irq, 0);
    // R2 not running
    idle(6);
    rd("R2 held", 5, 16'hFFFF, 0);
    // R10 pinned at zero
    wr(15, 0); wr(0, 8'h08); wr(1, 1);
    idle(10);
    rd("R10 pinned", 5, 16'hFFFF, 0);
    rd("R5 ch7 flag", 3, 8'h80, 8'h80);
    // R9 modulus reload
    wr(15, 10);
    wait_cnt(10, 40);
    cycle();
    rd("R9 reload", 5, 16'hFFFF, 0);
    // R12 set beats clear
    wr(15, 15); wr(8, 5); wr(3, 8'hFF);
    wait_cnt(5, 40);
    wr(3, 1);
    rd("R12 set wins", 3, 1, 1);
    // R5 R6 R7 free run
    wr(0, 0); wr(8, 40); wr(9, 45); wr(3, 8'hFF); wr(2, 8'h01);
    idle(50);
    rd("R5 ch0 ch1 flags", 3, 3, 3);
    chk("R7 irq on", chan_irq, 1);
    wr(3, 0);
    rd("R6 write zero", 3, 3, 3);
    wr(3, 8'h7F);
    rd("R6 write one", 3, 3, 0);
    chk("R7 irq off", chan_irq, 0);
    // R4 control layout
    wr(0, 16'hFFFF);
    rd("R4 readback", 0, 16'hFFFF, 16'h008F);
    wr(0, 8'h02);
    rd("R4 select", 0, 16'hFFFF, 2);
    // R3 divide by 4
    bus_addr = 4'd5; #1; c0 = bus_rdata;
    idle(8);
    rd("R3 ratio", 5, 16'hFFFF, (c0 + 2) % 65536);
    // R8 free-running wrap
    wr(0, 8'h80);
    for (int i = 0; i < 70000 && !m_ovf; i++) cycle();
    rd("R8 ovf flag", 4, 1, 1);
    chk("R8 ovf irq", ovf_irq, 1);
    wr(4, 1);
    rd("R6 ovf clear", 4, 1, 0);
    // R11 modulus at all ones
    wr(15, 16'hFFFF); wr(0, 8'h88);
    wait_cnt(65535, 70000);
    cycle();
    rd("R11 counter", 5, 16'hFFFF, 0);
    rd("R11 no overflow", 4, 1, 0);
    chk("R11 ovf irq", ovf_irq, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule